// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Range Fault

This block divides a 2N-bit dividend by an N-bit divisor. It returns an N-bit quotient and an N-bit remainder. A mode input chooses between an unsigned and a two's-complement signed reading of both operands. A request is a one-cycle `start` with the operands on the input pins. The block raises `busy` while it works and pulses `done` when the result is ready.

The divider does not return a result that cannot be right. When the divisor is zero, or when the true quotient does not fit in N bits under the selected reading, `divErr` pulses together with `done` and both result registers keep their earlier contents.

Signed division truncates toward zero, and a nonzero remainder carries the sign of the dividend. Internally the block divides magnitudes and fixes the signs in the last step. One quotient bit is decided per cycle.

A separate combinational output builds a 2N-bit value from an N-bit input by copying its top bit into the upper half. Software uses this to prepare a signed dividend.

Top module: `quo_rem_unit`

## Requirements
- R1: A `start` seen while `busy` is low is accepted and captures all operands and the mode. `busy` is high from the next cycle until `done`. A `start` while `busy` is high is ignored and does not change the pending result.
- R2: `done` is a one-cycle pulse that appears N+1 clock edges after the edge that accepted `start`. `busy` is low in the `done` cycle, so a new `start` may be given in that same cycle.
- R3: With `isSigned`=0 and a result that fits, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor. Both operands are read as unsigned. Example: 0007h / FEh gives quotient 00h and remainder 07h.
- R4: With `isSigned`=1 and a result that fits, the quotient is the exact quotient truncated toward zero. A nonzero remainder has the dividend's sign, and its magnitude is below that of the divisor. Examples: FFFBh / 02h gives FEh and FFh, and 0007h / FEh gives FDh and 01h.
- R5: A zero divisor raises `divErr` in either mode.
- R6: In unsigned mode, `divErr` is raised when the quotient is 2^N or more. Example: FFFBh / 02h.
- R7: In signed mode, `divErr` is raised when the exact quotient lies outside -2^(N-1) .. 2^(N-1)-1. Example: 00FBh / FFh faults. A quotient of exactly -2^(N-1) is valid, for example FF80h / 01h gives 80h.
- R8: `divErr` is high only in a `done` cycle. When it is high, `quotient` and `remainder` keep the values they had before.
- R9: `extOut` is, combinationally, `extIn` in its low N bits with N copies of `extIn[N-1]` above them. Example: 8Ah gives FF8Ah.
- R10: While `rstN` is low, `busy`, `done` and `divErr` are low and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division (accepted when not busy) |
| isSigned | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 2N | Dividend |
| divisor | input | N | Divisor |
| extIn | input | N | Value for the sign-extension helper |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| divErr | output | 1 | Fault pulse (zero divisor or quotient out of range), with done |
| quotient | output | N | Last valid quotient |
| remainder | output | N | Last valid remainder |
| extOut | output | 2N | extIn with its top bit copied into the upper half |

## Verification
The bench builds the block with N = 8. At this width every range edge can be driven directly: the -128 quotient that is just legal, +128 that is not, the -32768 / -1 extreme, and the unsigned 255/256 boundary. Each run finishes in nine cycles, so several hundred mixed signed and unsigned divisions fit in the run. Sign-extended dividends, small divisors and raw random words are mixed so that both valid results and faults occur often.

// File: rtl/qru_pkg.sv
`timescale 1ns/1ps
package qru_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } qruState_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic load;    // capture operands and convert to magnitudes
    logic check;   // evaluate zero divisor / high-half range
    logic step;    // decide one quotient bit
    logic finish;  // last step: sign fix-up and result write
  } qruStrobe_t;

endpackage

// File: rtl/qru_ctrl.sv
`timescale 1ns/1ps
module qru_ctrl
  import qru_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output qruStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  qruState_e stateQ;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe.load   = (stateQ == ST_IDLE) && start;
    strobe.check  = (stateQ == ST_CHECK);
    strobe.step   = (stateQ == ST_RUN);
    strobe.finish = (stateQ == ST_RUN) && (stepCnt == LAST);
  end

  assign busy = (stateQ != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      unique case (stateQ)
        ST_IDLE: begin
          if (strobe.load) stateQ <= ST_CHECK;
        end
        ST_CHECK: begin
          stateQ  <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          if (strobe.finish) begin
            stateQ <= ST_IDLE;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qru_datapath.sv
`timescale 1ns/1ps
module qru_datapath
  import qru_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  qruStrobe_t     strobe,
  input  logic           isSigned,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder,
  output logic           divErr
);

  localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};

  // operand conversion
  logic           ddNeg, dvNeg;
  logic [2*N-1:0] ddMag;
  logic [N-1:0]   dvMag;

  // iteration state
  logic [N-1:0] partRem;   // running partial remainder
  logic [N-1:0] lowBits;   // dividend low half shifting out, quotient shifting in
  logic [N-1:0] dvReg;
  logic         negQuo, negRem, modeSigned, earlyFault;

  // one step
  logic [N:0]   trial;
  logic         takeIt;
  logic [N-1:0] nextRem, nextLow;
  logic         rangeBad, fault;

  always_comb begin
    ddNeg = isSigned & dividend[2*N-1];
    dvNeg = isSigned & divisor[N-1];
    ddMag = ddNeg ? -dividend : dividend;
    dvMag = dvNeg ? -divisor : divisor;
  end

  always_comb begin
    trial   = {partRem, lowBits[N-1]};
    takeIt  = (trial >= {1'b0, dvReg});
    nextRem = takeIt ? (trial[N-1:0] - dvReg) : trial[N-1:0];
    nextLow = {lowBits[N-2:0], takeIt};
  end

  // Signed range: a negative result may reach HALF, a positive one must stay below it.
  always_comb begin
    rangeBad = modeSigned & (negQuo ? (nextLow > HALF) : nextLow[N-1]);
    fault    = earlyFault | rangeBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partRem    <= '0;
      lowBits    <= '0;
      dvReg      <= '0;
      negQuo     <= 1'b0;
      negRem     <= 1'b0;
      modeSigned <= 1'b0;
      earlyFault <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
      divErr     <= 1'b0;
    end else begin
      divErr <= strobe.finish & fault;
      if (strobe.load) begin
        partRem    <= ddMag[2*N-1:N];
        lowBits    <= ddMag[N-1:0];
        dvReg      <= dvMag;
        negQuo     <= ddNeg ^ dvNeg;
        negRem     <= ddNeg;
        modeSigned <= isSigned;
        earlyFault <= 1'b0;
      end
      if (strobe.check) begin
        // Quotient fits in N bits only when the high half is below the divisor.
        earlyFault <= (dvReg == '0) | (partRem >= dvReg);
      end
      if (strobe.step) begin
        partRem <= nextRem;
        lowBits <= nextLow;
      end
      if (strobe.finish && !fault) begin
        quotient  <= negQuo ? -nextLow : nextLow;
        remainder <= negRem ? -nextRem : nextRem;
      end
    end
  end

endmodule

// File: rtl/qru_signext.sv
`timescale 1ns/1ps
module qru_signext #(
  parameter int N = 8
) (
  input  logic [N-1:0]   narrow,
  output logic [2*N-1:0] wide
);

  for (genvar b = 0; b < 2*N; b++) begin : g_bit
    if (b < N) begin : g_low
      assign wide[b] = narrow[b];
    end else begin : g_fill
      assign wide[b] = narrow[N-1];
    end
  end

endmodule

// File: rtl/quo_rem_unit.sv
`timescale 1ns/1ps
module quo_rem_unit
  import qru_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           isSigned,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  input  logic [N-1:0]   extIn,
  output logic           busy,
  output logic           done,
  output logic           divErr,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder,
  output logic [2*N-1:0] extOut
);

  qruStrobe_t strobe;

  qru_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  qru_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .isSigned  (isSigned),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .divErr    (divErr)
  );

  qru_signext #(.N(N)) u_ext (
    .narrow (extIn),
    .wide   (extOut)
  );

endmodule

// File: rtl/qru_checker.sv
`timescale 1ns/1ps
module qru_checker #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           isSigned,
  input logic           ddMsb,
  input logic [N-1:0]   divisor,
  input logic           busy,
  input logic           done,
  input logic           divErr,
  input logic [N-1:0]   quotient,
  input logic [N-1:0]   remainder,
  input logic [N-1:0]   extIn,
  input logic [2*N-1:0] extOut
);

  logic [15:0]  sinceStart;
  logic [N-1:0] dvHold;
  logic         sgnHold, ddSignHold, zeroHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceStart <= '0;
      dvHold     <= '0;
      sgnHold    <= 1'b0;
      ddSignHold <= 1'b0;
      zeroHold   <= 1'b0;
    end else if (start && !busy) begin
      sinceStart <= '0;
      dvHold     <= divisor;
      sgnHold    <= isSigned;
      ddSignHold <= ddMsb;
      zeroHold   <= (divisor == '0);
    end else if (sinceStart != 16'hFFFF) begin
      sinceStart <= sinceStart + 16'd1;
    end
  end

  AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sinceStart == 16'(N + 1)); // R2
  AST_UNSIGNED_REM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    done && !divErr && !sgnHold |-> remainder < dvHold); // R3
  AST_SIGNED_REM_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    done && !divErr && sgnHold && (remainder != '0) |-> remainder[N-1] == ddSignHold); // R4
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    done && zeroHold |-> divErr); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> done); // R8
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> $stable(quotient) && $stable(remainder)); // R8
  AST_EXT_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (extOut[N-1:0] == extIn) && (extOut[2*N-1] == extIn[N-1]) &&
    (($countones(extOut[2*N-1:N]) == 0) || ($countones(extOut[2*N-1:N]) == N))); // R9

endmodule

bind quo_rem_unit qru_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .isSigned  (isSigned),
  .ddMsb     (dividend[2*N-1]),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .divErr    (divErr),
  .quotient  (quotient),
  .remainder (remainder),
  .extIn     (extIn),
  .extOut    (extOut)
);

// File: tb/quo_rem_unit_bench.sv
`timescale 1ns/1ps
module quo_rem_unit_bench;

  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic           isSigned = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]   divisor = '0;
  logic [W-1:0]   extIn = '0;
  logic           busy, done, divErr;
  logic [W-1:0]   quotient, remainder;
  logic [2*W-1:0] extOut;

  int checks = 0;
  int fails = 0;
  int watchdog = 0;

  always #2.5 clk = ~clk;

  quo_rem_unit #(.N(W)) u_quo_rem_unit (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .extIn(extIn),
    .busy(busy), .done(done), .divErr(divErr),
    .quotient(quotient), .remainder(remainder), .extOut(extOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference of the arithmetic (requirements R3..R7).
  function automatic void refDiv(input logic [2*W-1:0] dd, input logic [W-1:0] dv,
                                 input logic sg, output logic err,
                                 output logic [W-1:0] q, output logic [W-1:0] r);
    longint a, b, qq, rr;
    if (sg) begin
      a = longint'($signed(dd));
      b = longint'($signed(dv));
    end else begin
      a = longint'(dd);
      b = longint'(dv);
    end
    q = '0; r = '0;
    if (b == 0) begin
      err = 1'b1;
    end else begin
      qq = a / b;
      rr = a % b;
      if (sg) err = (qq < -(longint'(1) << (W-1))) || (qq > (longint'(1) << (W-1)) - 1);
      else    err = (qq > (longint'(1) << W) - 1);
      q = qq[W-1:0];
      r = rr[W-1:0];
    end
  endfunction

  // Cycle-by-cycle model
  logic         mBusy, mDone, mErr, pErr;
  logic [W-1:0] mQ, mR, pQ, pR;
  int           mCnt;

  always @(posedge clk) begin
    logic e;
    logic [W-1:0] q, r;
    if (!rstN) begin
      mBusy <= 0; mDone <= 0; mErr <= 0; mQ <= '0; mR <= '0; mCnt <= 0;
      pErr <= 0; pQ <= '0; pR <= '0;
    end else begin
      mDone <= 0; mErr <= 0;
      if (!mBusy) begin
        if (start) begin
          refDiv(dividend, divisor, isSigned, e, q, r);
          pErr <= e; pQ <= q; pR <= r;
          mBusy <= 1; mCnt <= 0;
        end
      end else if (mCnt == W) begin
        mBusy <= 0; mDone <= 1; mErr <= pErr;
        if (!pErr) begin mQ <= pQ; mR <= pR; end
      end else begin
        mCnt <= mCnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    chk("R1 busy", 32'(busy), 32'(mBusy));
    chk("R2 done", 32'(done), 32'(mDone));
    chk("R6 divErr", 32'(divErr), 32'(mErr));
    chk("R3 quotient", 32'(quotient), 32'(mQ));
    chk("R3 remainder", 32'(remainder), 32'(mR));
    chk("R9 extOut", 32'(extOut), 32'({{W{extIn[W-1]}}, extIn}));
  end

  always @(posedge clk) begin
    watchdog++;
    if (watchdog > 150000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Runs one division; checks latency, fault/hold and the reference result.
  task automatic doOp(input logic [2*W-1:0] dd, input logic [W-1:0] dv, input logic sg,
                      input string tag, input logic poke);
    logic e;
    logic [W-1:0] q, r, oldQ, oldR;
    int cyc;
    refDiv(dd, dv, sg, e, q, r);
    @(negedge clk);
    oldQ = quotient; oldR = remainder;
    start = 1; dividend = dd; divisor = dv; isSigned = sg; extIn = W'($urandom);
    @(negedge clk);
    start = 0; cyc = 1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start = 1; dividend = ~dd; divisor = dv + 1'b1; isSigned = ~sg;
      end else if (poke && cyc == 4) begin
        start = 0;
      end
    end
    chk({tag, " R2 latency"}, 32'(cyc), 32'(W + 2));
    chk({tag, " divErr"}, 32'(divErr), 32'(e));
    if (e) begin
      chk("R8 quotient held", 32'(quotient), 32'(oldQ));
      chk("R8 remainder held", 32'(remainder), 32'(oldR));
    end else begin
      chk({tag, " quotient"}, 32'(quotient), 32'(q));
      chk({tag, " remainder"}, 32'(remainder), 32'(r));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 divErr", 32'(divErr), 0);
    chk("R10 quotient", 32'(quotient), 0);
    chk("R10 remainder", 32'(remainder), 0);
    rstN = 1;

    // R9 helper, direct values
    @(negedge clk); extIn = 8'h8A; #1 chk("R9 neg", 32'(extOut), 32'h0000FF8A);
    extIn = 8'h7F; #1 chk("R9 pos", 32'(extOut), 32'h0000007F);

    doOp(16'h0007, 8'hFE, 0, "R3", 0);
    chk("R3 q 0007/FE", 32'(quotient), 32'h00); chk("R3 r 0007/FE", 32'(remainder), 32'h07);
    doOp(16'h0007, 8'hFE, 1, "R4", 0);
    chk("R4 q 7/-2", 32'(quotient), 32'hFD); chk("R4 r 7/-2", 32'(remainder), 32'h01);
    doOp(16'hFFFB, 8'h02, 1, "R4", 0);
    chk("R4 q -5/2", 32'(quotient), 32'hFE); chk("R4 r -5/2", 32'(remainder), 32'hFF);
    doOp(16'hFFFB, 8'h02, 0, "R6", 0);
    chk("R6 unsigned overflow", 32'(divErr), 1);
    doOp(16'h00FB, 8'hFF, 1, "R7", 0);
    chk("R7 251/-1 overflow", 32'(divErr), 1);
    chk("R8 hold q", 32'(quotient), 32'hFE);
    doOp(16'hFF80, 8'h01, 1, "R7", 0);
    chk("R7 -128 legal", 32'(quotient), 32'h80);
    doOp(16'h0080, 8'h01, 1, "R7", 0);
    chk("R7 +128 overflow", 32'(divErr), 1);
    doOp(16'h8000, 8'hFF, 1, "R7", 0);
    doOp(16'h1234, 8'h00, 0, "R5", 0);
    chk("R5 zero unsigned", 32'(divErr), 1);
    doOp(16'hF234, 8'h00, 1, "R5", 0);
    chk("R5 zero signed", 32'(divErr), 1);
    doOp(16'hFEFF, 8'hFF, 0, "R3", 0);
    chk("R3 q FEFF/FF", 32'(quotient), 32'hFF); chk("R3 r FEFF/FF", 32'(remainder), 32'hFE);
    doOp(16'hFF00, 8'hFF, 0, "R6", 0);
    chk("R6 quotient 256", 32'(divErr), 1);
    // R1: start while busy ignored
    doOp(16'h0064, 8'h07, 0, "R1", 1);
    chk("R1 ignored start q", 32'(quotient), 32'd14);
    chk("R1 ignored start r", 32'(remainder), 32'd2);

    for (int i = 0; i < 400; i++) begin
      logic [2*W-1:0] dd;
      logic [W-1:0] dv;
      logic [W-1:0] lo;
      lo = W'($urandom);
      case (i % 3)
        0: dd = {{W{lo[W-1]}}, lo};
        1: dd = 16'($urandom) >> ($urandom % 9);
        default: dd = 16'($urandom);
      endcase
      dv = (i % 4 == 0) ? W'($urandom % 5) : W'($urandom);
      doOp(dd, dv, 1'(i % 2), (i % 2) ? "R4" : "R3", 1'(i % 7 == 0));
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule